// File: doc/BRIEF.md
# Relative Branch Target and Return Stack Unit

This block works out the next program counter for a processor whose program memory is addressed in 4-bit nibbles through a 20-bit counter. Each cycle the fetch stage presents the address of the current opcode, its total length in nibbles, the position of the offset field inside it, a branch class, a condition result, and the offset nibbles as they were read. Offset nibbles are packed first-read-lowest, so `ofs_in[3:0]` is the first offset nibble from the stream. The block returns the next program counter within the same cycle. Each branch class adds its offset to its own base. Calls, returns and explicit register exchanges update a small hardware return stack on the next clock edge.

A conditional branch whose 8-bit offset is zero becomes a conditional return. A call saves the address of the instruction after it, which is the opcode address plus the length. Exchanging a register with the program counter gives the register that same following address and jumps to the register's old value. The indirect jump takes the 20-bit word that fetch has already read from the address held in A or C. The four return variants also pulse a side-effect strobe. All address arithmetic wraps modulo 2^20.

Top module: `brs_unit`

## Requirements
- R1: With `op_code` 1 (conditional branch) and `cond_in` high, and with `ofs_in[7:0]` not zero, `next_pc` is `pc_in + ofs_pos_in` plus `ofs_in[7:0]` read as a signed 8-bit value. With `cond_in` low, `next_pc` is `pc_in + len_in`.
- R2: With `op_code` 1, `cond_in` high and `ofs_in[7:0]` equal to zero, the branch is a return. `next_pc` is the stack top and the entry is popped. With `cond_in` low the stack is left unchanged.
- R3: `op_code` 2 jumps to `pc_in + 1` plus the signed 12-bit `ofs_in[11:0]`. `op_code` 3 jumps to `pc_in + 2` plus the signed 16-bit `ofs_in[15:0]`.
- R4: `op_code` 4 calls `pc_in + 4` plus the signed 12-bit offset. `op_code` 5 calls `pc_in + 6` plus the signed 16-bit offset. Both push `pc_in + len_in`, which becomes the new stack top after the edge.
- R5: `op_code` 6 loads `next_pc` with `ofs_in`. `op_code` 7 does the same and also pushes `pc_in + len_in`.
- R6: `op_code` 8 (indirect) loads `next_pc` from `mem_in`.
- R7: `op_code` 9 (exchange with PC) drives `next_pc = reg_in`, `reg_out = pc_in + len_in` and `reg_we = 1`.
- R8: `op_code` 10 to 14 pop the stack into `next_pc`. The side-effect strobes `{carry_set,carry_clr,xm_set,int_en}` are 0000 for code 10, 1000 for 11, 0100 for 12, 0010 for 13 and 0001 for 14. For every other code they are 0000.
- R9: `op_code` 15 pushes `reg_in`. `op_code` 16 pops the top into `reg_out` with `reg_we = 1`. Both continue at `pc_in + len_in`.
- R10: Pushing onto a full 8-entry stack discards the oldest entry, and `stk_depth` stays 8. `stk_flat[20*i +: 20]` is the i-th entry counted from the top, and slots at or beyond the depth read zero.
- R11: A pop from an empty stack yields 0 and leaves `stk_depth` at 0.
- R12: All program counter sums wrap modulo 2^20.
- R13: After reset `stk_depth` is 0 and `stk_flat` is all zeros.
- R14: With `op_valid` low, or with an unused `op_code` (0 or 17 to 31), `next_pc` is `pc_in + len_in` and the stack, `reg_we` and the strobes do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An instruction is presented this cycle |
| op_code | input | 5 | Branch class (see requirements) |
| pc_in | input | 20 | Address of the opcode |
| len_in | input | 4 | Instruction length in nibbles |
| ofs_pos_in | input | 4 | Nibble position of the offset field within the instruction |
| cond_in | input | 1 | Condition result for a conditional branch |
| ofs_in | input | 20 | Offset or address nibbles, first-read nibble lowest |
| reg_in | input | 20 | Address field of the register A or C |
| mem_in | input | 20 | Word read at the address in `reg_in`, for indirect jumps |
| next_pc | output | 20 | Next program counter |
| reg_out | output | 20 | Value to write into the register |
| reg_we | output | 1 | Write strobe for `reg_out` |
| carry_set | output | 1 | Return sets carry |
| carry_clr | output | 1 | Return clears carry |
| xm_set | output | 1 | Return sets the XM flag |
| int_en | output | 1 | Return re-enables interrupts |
| stk_depth | output | 4 | Number of valid stack entries |
| stk_flat | output | 160 | Stack contents, top in the lowest 20 bits |

## Verification
The bench steers negative offsets and sums near the top of the address space. A design that zero-extends the offset, or carries into a 21st bit, sends the program counter to the wrong place. It drives a zero offset with the condition both true and false: mixing these up turns an untaken branch into a stray return, or makes a taken return jump in place. It pushes nine times and pops past empty. An overflow that drops the newest entry instead of the oldest returns to the wrong caller, and an underflow that wraps the pointer returns stale addresses instead of zero. Random mixes of calls, returns and exchanges then check that each class uses its own base (opcode address, offset address, or following instruction).

// File: rtl/brs_pkg.sv
`timescale 1ns/1ps
package brs_pkg;
   localparam int PC_W      = 20;
   localparam int STK_DEPTH = 8;

   typedef enum logic [4:0] {
      OP_SEQ    = 5'd0,
      OP_BRC    = 5'd1,
      OP_JR3    = 5'd2,
      OP_JR4    = 5'd3,
      OP_CR3    = 5'd4,
      OP_CR4    = 5'd5,
      OP_JABS   = 5'd6,
      OP_CABS   = 5'd7,
      OP_JIND   = 5'd8,
      OP_XPC    = 5'd9,
      OP_RET    = 5'd10,
      OP_RET_SC = 5'd11,
      OP_RET_CC = 5'd12,
      OP_RET_XM = 5'd13,
      OP_RET_IE = 5'd14,
      OP_PUSHR  = 5'd15,
      OP_POPR   = 5'd16
   } brs_op_e;
endpackage

// File: rtl/brs_target.sv
`timescale 1ns/1ps
// Candidate targets for every relative class; the adders wrap at W bits.
module brs_target #(
   parameter int W = 20
) (
   input  logic [W-1:0] pc,
   input  logic [3:0]   len,
   input  logic [3:0]   ofs_pos,
   input  logic [W-1:0] ofs,
   output logic [W-1:0] t_seq,
   output logic [W-1:0] t_brc,
   output logic [W-1:0] t_jr3,
   output logic [W-1:0] t_jr4,
   output logic [W-1:0] t_cr3,
   output logic [W-1:0] t_cr4
);
   if (W < 16) begin : g_bad_width
      $error("brs_target: W must hold a 16-bit offset");
   end

   logic [W-1:0] sx8, sx12, sx16;

   always_comb begin
      sx8   = {{(W-8){ofs[7]}},   ofs[7:0]};
      sx12  = {{(W-12){ofs[11]}}, ofs[11:0]};
      sx16  = {{(W-16){ofs[15]}}, ofs[15:0]};
      t_seq = pc + W'(len);
      t_brc = pc + W'(ofs_pos) + sx8;
      t_jr3 = pc + W'(1) + sx12;
      t_jr4 = pc + W'(2) + sx16;
      t_cr3 = pc + W'(4) + sx12;
      t_cr4 = pc + W'(6) + sx16;
   end
endmodule

// File: rtl/brs_stack.sv
`timescale 1ns/1ps
// Circular return stack: overflow overwrites the oldest slot, underflow reads zero.
module brs_stack #(
   parameter int W     = 20,
   parameter int DEPTH = 8,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push,
   input  logic               pop,
   input  logic [W-1:0]       push_data,
   output logic [W-1:0]       pop_data,
   output logic [CW-1:0]      depth,
   output logic [DEPTH*W-1:0] flat
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("brs_stack: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp;
   logic          empty, full;

   assign empty    = (depth == '0);
   assign full     = (depth == CW'(DEPTH));
   assign pop_data = empty ? '0 : mem[wp - PW'(1)];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp    <= '0;
         depth <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (push) begin
         mem[wp] <= push_data;
         wp      <= wp + PW'(1);
         if (!full) depth <= depth + CW'(1);
      end else if (pop && !empty) begin
         wp    <= wp - PW'(1);
         depth <= depth - CW'(1);
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_view
      logic [PW-1:0] idx;
      assign idx = wp - PW'(i + 1);
      assign flat[i*W +: W] = (CW'(i) < depth) ? mem[idx] : '0;
   end

   assert_depth_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      depth <= CW'(DEPTH));
   assert_full_push_saturates_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push) |=> (depth == CW'(DEPTH)));
   assert_empty_pop_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> (depth == '0));
   assert_push_lands_on_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> (flat[W-1:0] == $past(push_data)));
endmodule

// File: rtl/brs_unit.sv
`timescale 1ns/1ps
module brs_unit
   import brs_pkg::*;
#(
   parameter int PCW   = brs_pkg::PC_W,
   parameter int DEPTH = brs_pkg::STK_DEPTH,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               op_valid,
   input  logic [4:0]         op_code,
   input  logic [PCW-1:0]     pc_in,
   input  logic [3:0]         len_in,
   input  logic [3:0]         ofs_pos_in,
   input  logic               cond_in,
   input  logic [PCW-1:0]     ofs_in,
   input  logic [PCW-1:0]     reg_in,
   input  logic [PCW-1:0]     mem_in,
   output logic [PCW-1:0]     next_pc,
   output logic [PCW-1:0]     reg_out,
   output logic               reg_we,
   output logic               carry_set,
   output logic               carry_clr,
   output logic               xm_set,
   output logic               int_en,
   output logic [CW-1:0]      stk_depth,
   output logic [DEPTH*PCW-1:0] stk_flat
);
   logic [PCW-1:0] t_seq, t_brc, t_jr3, t_jr4, t_cr3, t_cr4;
   logic [PCW-1:0] pop_data, push_data;
   logic           push, pop;
   brs_op_e        op;

   assign op = brs_op_e'(op_code);

   brs_target #(.W(PCW)) u_tgt (
      .pc(pc_in), .len(len_in), .ofs_pos(ofs_pos_in), .ofs(ofs_in),
      .t_seq(t_seq), .t_brc(t_brc), .t_jr3(t_jr3), .t_jr4(t_jr4),
      .t_cr3(t_cr3), .t_cr4(t_cr4)
   );

   brs_stack #(.W(PCW), .DEPTH(DEPTH)) u_stk (
      .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
      .push_data(push_data), .pop_data(pop_data),
      .depth(stk_depth), .flat(stk_flat)
   );

   always_comb begin
      next_pc   = t_seq;
      reg_out   = '0;
      reg_we    = 1'b0;
      push      = 1'b0;
      pop       = 1'b0;
      push_data = t_seq;
      carry_set = 1'b0;
      carry_clr = 1'b0;
      xm_set    = 1'b0;
      int_en    = 1'b0;
      if (op_valid) begin
         case (op)
            OP_BRC: if (cond_in) begin
               if (ofs_in[7:0] == 8'h00) begin
                  pop     = 1'b1;
                  next_pc = pop_data;
               end else begin
                  next_pc = t_brc;
               end
            end
            OP_JR3:  next_pc = t_jr3;
            OP_JR4:  next_pc = t_jr4;
            OP_CR3:  begin next_pc = t_cr3;  push = 1'b1; end
            OP_CR4:  begin next_pc = t_cr4;  push = 1'b1; end
            OP_JABS: next_pc = ofs_in;
            OP_CABS: begin next_pc = ofs_in; push = 1'b1; end
            OP_JIND: next_pc = mem_in;
            OP_XPC:  begin next_pc = reg_in; reg_out = t_seq; reg_we = 1'b1; end
            OP_RET, OP_RET_SC, OP_RET_CC, OP_RET_XM, OP_RET_IE: begin
               pop       = 1'b1;
               next_pc   = pop_data;
               carry_set = (op == OP_RET_SC);
               carry_clr = (op == OP_RET_CC);
               xm_set    = (op == OP_RET_XM);
               int_en    = (op == OP_RET_IE);
            end
            OP_PUSHR: begin push = 1'b1; push_data = reg_in; end
            OP_POPR:  begin pop = 1'b1; reg_out = pop_data; reg_we = 1'b1; end
            default: ;
         endcase
      end
   end

   assert_strobes_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({carry_set, carry_clr, xm_set, int_en}));
   assert_idle_keeps_stack_R14: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(stk_depth));
   assert_idle_no_write_R14: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |-> !reg_we);
   assert_call_grows_stack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op == OP_CR3 || op == OP_CR4) && stk_depth < CW'(DEPTH))
      |=> (stk_depth == $past(stk_depth) + CW'(1)));
endmodule

// File: tb/sim_brs_unit.sv
`timescale 1ns/1ps
module sim_brs_unit;
   logic         clk = 0, rst_n = 0;
   logic         op_valid = 0, cond_in = 0;
   logic [4:0]   op_code = 0;
   logic [19:0]  pc_in = 0, ofs_in = 0, reg_in = 0, mem_in = 0;
   logic [3:0]   len_in = 0, ofs_pos_in = 0;
   logic [19:0]  next_pc, reg_out;
   logic         reg_we, carry_set, carry_clr, xm_set, int_en;
   logic [3:0]   stk_depth;
   logic [159:0] stk_flat;

   int errors = 0, checks = 0;
   logic [19:0] mdl [8];
   int          mdl_depth = 0;

   always #10 clk = ~clk;

   brs_unit u0 (.*);

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic int sx(input int v, input int bits);
      return (v >= (1 << (bits - 1))) ? v - (1 << bits) : v;
   endfunction

   task automatic check_stack(input string tag);
      chk(tag, "depth", 32'(stk_depth), 32'(mdl_depth));
      for (int i = 0; i < 8; i++)
         chk(tag, $sformatf("slot%0d", i), 32'(stk_flat[i*20 +: 20]), 32'(mdl[i]));
   endtask

   task automatic mdl_push(input logic [19:0] v);
      for (int i = 7; i > 0; i--) mdl[i] = mdl[i-1];
      mdl[0] = v;
      if (mdl_depth < 8) mdl_depth++;
   endtask

   task automatic mdl_pop();
      if (mdl_depth > 0) begin
         for (int i = 0; i < 7; i++) mdl[i] = mdl[i+1];
         mdl[7] = '0;
         mdl_depth--;
      end
   endtask

   task automatic apply(input bit vld, input logic [4:0] op, input logic [19:0] pc,
                        input logic [3:0] len, input logic [3:0] pos, input bit cnd,
                        input logic [19:0] ofs, input logic [19:0] rg, input logic [19:0] mv,
                        input string tag);
      logic [31:0] e_next, e_rout, seq;
      logic [3:0]  e_fl;
      bit          e_we, do_push, do_pop;
      logic [19:0] pv, top;
      @(negedge clk);
      check_stack(tag);
      op_valid = vld; op_code = op; pc_in = pc; len_in = len; ofs_pos_in = pos;
      cond_in = cnd; ofs_in = ofs; reg_in = rg; mem_in = mv;
      seq  = 32'(pc) + 32'(len);
      top  = (mdl_depth > 0) ? mdl[0] : 20'h0;
      e_next = seq; e_rout = 0; e_we = 0; e_fl = 4'b0000;
      do_push = 0; do_pop = 0; pv = seq[19:0];
      if (vld) begin
         case (op)
            5'd1: if (cnd) begin
               if (ofs[7:0] == 8'h00) begin do_pop = 1; e_next = 32'(top); end
               else e_next = 32'(pc) + 32'(pos) + 32'(sx(int'(ofs[7:0]), 8));
            end
            5'd2: e_next = 32'(pc) + 1 + 32'(sx(int'(ofs[11:0]), 12));
            5'd3: e_next = 32'(pc) + 2 + 32'(sx(int'(ofs[15:0]), 16));
            5'd4: begin e_next = 32'(pc) + 4 + 32'(sx(int'(ofs[11:0]), 12)); do_push = 1; end
            5'd5: begin e_next = 32'(pc) + 6 + 32'(sx(int'(ofs[15:0]), 16)); do_push = 1; end
            5'd6: e_next = 32'(ofs);
            5'd7: begin e_next = 32'(ofs); do_push = 1; end
            5'd8: e_next = 32'(mv);
            5'd9: begin e_next = 32'(rg); e_rout = seq; e_we = 1; end
            5'd10, 5'd11, 5'd12, 5'd13, 5'd14: begin
               do_pop = 1; e_next = 32'(top);
               e_fl = (op == 5'd11) ? 4'b1000 : (op == 5'd12) ? 4'b0100 :
                      (op == 5'd13) ? 4'b0010 : (op == 5'd14) ? 4'b0001 : 4'b0000;
            end
            5'd15: begin do_push = 1; pv = rg; end
            5'd16: begin do_pop = 1; e_rout = 32'(top); e_we = 1; end
            default: ;
         endcase
      end
      #2;
      chk(tag, "next_pc", 32'(next_pc), {12'h0, e_next[19:0]});
      chk(tag, "reg_we", 32'(reg_we), 32'(e_we));
      if (e_we) chk(tag, "reg_out", 32'(reg_out), {12'h0, e_rout[19:0]});
      chk(tag, "strobes", 32'({carry_set, carry_clr, xm_set, int_en}), 32'(e_fl));
      @(posedge clk);
      if (do_push) mdl_push(pv);
      else if (do_pop) mdl_pop();
   endtask

   initial begin
      #(20 * 200000);
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) mdl[i] = '0;
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_stack("R13 reset");
      rst_n = 1;
      // conditional branches
      apply(1, 5'd1, 20'h01000, 4'd3, 4'd1, 0, 20'h00012, 0, 0, "R1 untaken");
      apply(1, 5'd1, 20'h01000, 4'd3, 4'd1, 1, 20'h00012, 0, 0, "R1 forward");
      apply(1, 5'd1, 20'h01000, 4'd7, 4'd5, 1, 20'h000F6, 0, 0, "R1 backward");
      apply(1, 5'd1, 20'h02000, 4'd3, 4'd1, 1, 20'h00000, 0, 0, "R11 empty return");
      // relative jumps, wrap
      apply(1, 5'd2, 20'h00000, 4'd4, 4'd1, 0, 20'h00FFA, 0, 0, "R12 jr3 wrap low");
      apply(1, 5'd3, 20'hFFFFE, 4'd6, 4'd2, 0, 20'h01000, 0, 0, "R12 jr4 wrap high");
      apply(1, 5'd2, 20'h10000, 4'd4, 4'd1, 0, 20'h001C6, 0, 0, "R3 jr3");
      apply(1, 5'd3, 20'h10000, 4'd6, 4'd2, 0, 20'h0E020, 0, 0, "R3 jr4 back");
      // calls and returns
      apply(1, 5'd4, 20'h20000, 4'd4, 4'd1, 0, 20'h00040, 0, 0, "R4 cr3");
      apply(1, 5'd5, 20'h30000, 4'd6, 4'd2, 0, 20'h0E020, 0, 0, "R4 cr4");
      apply(1, 5'd7, 20'h40000, 4'd7, 4'd2, 0, 20'hC0020, 0, 0, "R5 cabs");
      apply(1, 5'd6, 20'h40000, 4'd7, 4'd2, 0, 20'h12345, 0, 0, "R5 jabs");
      apply(1, 5'd1, 20'h50000, 4'd3, 4'd1, 0, 20'h00000, 0, 0, "R2 untaken zero");
      apply(1, 5'd1, 20'h50000, 4'd3, 4'd1, 1, 20'h00000, 0, 0, "R2 cond return");
      apply(1, 5'd11, 20'h0, 4'd2, 4'd0, 0, 0, 0, 0, "R8 ret set carry");
      apply(1, 5'd12, 20'h0, 4'd2, 4'd0, 0, 0, 0, 0, "R8 ret clr carry");
      apply(1, 5'd13, 20'h0, 4'd2, 4'd0, 0, 0, 0, 0, "R8 ret set xm");
      apply(1, 5'd14, 20'h0, 4'd2, 4'd0, 0, 0, 0, 0, "R8 ret int en");
      apply(1, 5'd8, 20'h6000, 4'd4, 4'd0, 0, 0, 20'h0ABCD, 20'h54321, "R6 indirect");
      apply(1, 5'd9, 20'h7000, 4'd4, 4'd0, 0, 0, 20'h0BEEF, 0, "R7 exchange");
      // overflow: nine pushes
      for (int i = 0; i < 9; i++)
         apply(1, 5'd15, 20'h8000, 4'd2, 4'd0, 0, 0, 20'hA0000 + 20'(i), 0, "R10 push full");
      apply(0, 5'd15, 20'h8000, 4'd2, 4'd0, 0, 0, 20'hFFFFF, 0, "R14 invalid push");
      apply(1, 5'd17, 20'h8000, 4'd2, 4'd0, 1, 0, 20'hFFFFF, 0, "R14 unused code");
      for (int i = 0; i < 9; i++)
         apply(1, 5'd16, 20'h8000, 4'd2, 4'd0, 0, 0, 0, 0, "R9 pop register");
      apply(1, 5'd10, 20'h9000, 4'd2, 4'd0, 0, 0, 0, 0, "R11 ret empty");
      // random mix
      for (int n = 0; n < 400; n++) begin
         logic [19:0] r_ofs;
         r_ofs = 20'($urandom);
         if ($urandom % 4 == 0) r_ofs[7:0] = 8'h00;
         apply(($urandom % 8) != 0, 5'($urandom % 18), 20'($urandom), 4'($urandom),
               4'($urandom), 1'($urandom), r_ofs, 20'($urandom), 20'($urandom),
               "R12 random mix");
      end
      @(negedge clk);
      check_stack("R10 final");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule